// File: doc/BRIEF.md
# Banked Memory Management Unit

This block sits between an 8-bit processor with a 16-bit address bus and a 128 KB RAM split into two 64 KB banks. Every processor access is decoded in the same cycle to a single target. The possible targets are RAM, the low ROM, the high ROM, the top ROM, the character ROM, the I/O space, the nibble-wide colour RAM or the unit's own registers. For RAM accesses the block also produces a 17-bit physical address. The block returns read data to the processor. It forwards the data of the selected target, substitutes its own register contents, or returns 0xFF when nothing answers.

The layout is set by a configuration byte. Software can write that byte directly. It can also load it in a single write from one of four preset registers. Page 0 and page 1 can each be moved to any 256-byte page in either bank, and the moved page is swapped into the place they left. An optional window at the bottom or the top of the address space can be shared, so that bank-1 accesses inside it land in bank 0. Writes to an address whose read would be served by a ROM go to the RAM underneath that ROM.

Top module: `mmu_banker`

## Requirements
- R1: After a synchronous active-high reset, the registers read back as follows: configuration 0x00 at 0xD500, mode 0xB9 at 0xD505, RAM configuration 0x00 at 0xD506, zero-page page and bank 0x00 at 0xD507/0xD508, stack page 0x01 at 0xD509 and stack bank 0x00 at 0xD50A. The mode-switch request output is low.
- R2: With configuration bit 0 clear, 0xD000–0xDFFF is I/O space. Inside it, 0xD500–0xD50B are the unit's registers and 0xD800–0xDBFF are colour RAM. With bit 0 set, that range falls through to the ROM or RAM decode.
- R3: A read in 0x4000–0x7FFF selects low ROM when bit 1 is clear and RAM when it is set. A read in 0x8000–0xBFFF selects high ROM when bits 3:2 are 00 and RAM when they are 11. A read in 0xC000–0xFFFF selects top ROM when bits 5:4 are 00, with character ROM in 0xD000–0xDFFF, and selects RAM when those bits are 11. Any other code leaves all selects low and returns 0xFF. ROM reads return the ROM data input, and RAM reads return the RAM data input.
- R4: Configuration bit 6 sets bit 16 of the RAM address, which selects bank 1.
- R5: A write to an address whose read would hit a ROM, or would be unmapped, selects RAM at that address.
- R6: 0xFF00 reads and writes the configuration register in every configuration. A write of any value to 0xFF01–0xFF04 copies preset register 1–4 (0xD501–0xD504) into the configuration register.
- R7: Page 0x00 maps to the zero-page register pair {bank bit 0, page}, and page 0x01 maps to the stack pair. An access to the selected page of the selected bank is swapped to page 0x00 or page 0x01 of that bank.
- R8: When RAM-configuration bits 3:2 are nonzero, a bank-1 RAM address inside the shared window goes to bank 0. Bits 1:0 give the window size: 00 = 1K, 01 = 4K, 10 = 8K, 11 = 16K. Bit 2 shares the bottom of the address space and bit 3 shares the top.
- R9: 0xD50B is a read-only version register that reads 0x20. Writes to it have no effect.
- R10: A colour RAM read returns the 4-bit colour input in bits 3:0, with bits 7:4 forced to 1111.
- R11: A write to the mode register (0xD505) stores the byte. If bit 6 of the written byte is set, modeReq is high for exactly the one cycle after the write edge. Otherwise modeReq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuAddr | input | 16 | Processor address |
| cpuWe | input | 1 | Write strobe for this cycle |
| cpuWrData | input | 8 | Processor write data |
| cpuRdData | output | 8 | Read data returned to the processor |
| ramRdData | input | 8 | Data from RAM |
| romRdData | input | 8 | Data from the selected ROM |
| ioRdData | input | 8 | Data from I/O peripherals |
| colRdData | input | 4 | Data from colour RAM |
| ramAddr | output | 17 | Physical RAM address (bit 16 = bank) |
| selRam | output | 1 | RAM is the target |
| selLoRom | output | 1 | Low ROM is the target |
| selHiRom | output | 1 | High ROM is the target |
| selTopRom | output | 1 | Top ROM is the target |
| selChar | output | 1 | Character ROM is the target |
| selIo | output | 1 | I/O space is the target |
| selColour | output | 1 | Colour RAM is the target |
| modeReq | output | 1 | One-cycle mode-switch request |

## Verification
The decode is purely combinational. Selects, ramAddr and cpuRdData are therefore due in the same cycle that the address is applied. The bench drives the address on the falling edge and samples 2 ns later, well before the next rising edge. Register writes take effect at the rising edge that samples cpuWe, so any read that depends on a write is issued at the following falling edge. modeReq is registered: it is checked high one half-cycle after the write edge and low one full cycle later.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [3:0] {
    TGT_NONE, TGT_RAM, TGT_LOROM, TGT_HIROM, TGT_TOPROM,
    TGT_CHAR, TGT_IO, TGT_COLOUR, TGT_REG
  } target_e;

  // write strobes from control to the register datapath
  typedef struct packed {
    logic       regWr;
    logic [3:0] regIdx;
    logic       preLoad;
    logic [1:0] preIdx;
  } strobes_t;

  typedef struct packed {
    logic [7:0]      cfg;
    logic [3:0][7:0] pre;
    logic [7:0]      mode;
    logic [7:0]      ramCfg;
    logic [7:0]      zpPage;
    logic [7:0]      zpBank;
    logic [7:0]      spPage;
    logic [7:0]      spBank;
  } regs_t;
endpackage

// File: rtl/mmu_ctrl.sv
module mmu_ctrl
  import mmu_pkg::*;
#(
  parameter logic [15:0] REG_BASE = 16'hD500,
  parameter logic [15:0] MIRROR_BASE = 16'hFF00
) (
  input  logic [15:0] cpuAddr,
  input  logic        cpuWe,
  input  logic        ioVisible,
  output strobes_t    strb
);
  localparam int unsigned LAST_RW_IDX = 10;
  localparam int unsigned NUM_PRE = 4;

  logic winHit;
  logic mirHit;

  always_comb begin
    winHit = ioVisible && (cpuAddr[15:4] == REG_BASE[15:4]) &&
             (int'(cpuAddr[3:0]) <= LAST_RW_IDX);
    mirHit = (cpuAddr[15:3] == MIRROR_BASE[15:3]) &&
             (int'(cpuAddr[2:0]) <= NUM_PRE);
    strb.regWr   = cpuWe && (winHit || (mirHit && cpuAddr[2:0] == 3'd0));
    strb.regIdx  = mirHit ? 4'd0 : cpuAddr[3:0];
    strb.preLoad = cpuWe && mirHit && (cpuAddr[2:0] != 3'd0);
    strb.preIdx  = 2'(cpuAddr[2:0] - 3'd1);
  end
endmodule

// File: rtl/mmu_regfile.sv
module mmu_regfile
  import mmu_pkg::*;
#(
  parameter logic [7:0] MODE_RST = 8'hB9,
  parameter logic [7:0] SP_RST_PAGE = 8'h01
) (
  input  logic       clk,
  input  logic       rst,
  input  strobes_t   strb,
  input  logic [7:0] wrData,
  output regs_t      regs,
  output logic       modeReq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      regs.cfg    <= '0;
      regs.pre    <= '0;
      regs.mode   <= MODE_RST;
      regs.ramCfg <= '0;
      regs.zpPage <= '0;
      regs.zpBank <= '0;
      regs.spPage <= SP_RST_PAGE;
      regs.spBank <= '0;
      modeReq     <= 1'b0;
    end else begin
      modeReq <= 1'b0;
      if (strb.regWr) begin
        case (strb.regIdx)
          4'd0: regs.cfg <= wrData;
          4'd1, 4'd2, 4'd3, 4'd4: regs.pre[2'(strb.regIdx - 4'd1)] <= wrData;
          4'd5: begin
            regs.mode <= wrData;
            modeReq   <= wrData[6];
          end
          4'd6:  regs.ramCfg <= wrData;
          4'd7:  regs.zpPage <= wrData;
          4'd8:  regs.zpBank <= wrData;
          4'd9:  regs.spPage <= wrData;
          4'd10: regs.spBank <= wrData;
          default: ;
        endcase
      end
      if (strb.preLoad) regs.cfg <= regs.pre[strb.preIdx];
    end
  end
endmodule

// File: rtl/mmu_map.sv
module mmu_map
  import mmu_pkg::*;
#(
  parameter logic [7:0] VERSION_ID = 8'h20
) (
  input  logic [15:0] cpuAddr,
  input  logic        cpuWe,
  input  regs_t       regs,
  input  logic [7:0]  ramRdData,
  input  logic [7:0]  romRdData,
  input  logic [7:0]  ioRdData,
  input  logic [3:0]  colRdData,
  output target_e     tgt,
  output logic [16:0] ramAddr,
  output logic [7:0]  cpuRdData
);
  logic        ioWin, mirWin;
  logic [8:0]  zpSel, spSel;
  logic [16:0] virt, phys;
  logic [15:0] invLow;
  logic [3:0]  shAmt;
  logic        botShare, topShare;
  logic [3:0]  rdIdx;
  logic [7:0]  regVal;
  target_e     rdTgt;

  // target decode
  always_comb begin
    ioWin  = !regs.cfg[0] && (cpuAddr[15:12] == 4'hD);
    mirWin = (cpuAddr[15:3] == 13'h1FE0) && (cpuAddr[2:0] <= 3'd4);
    if (mirWin) rdTgt = TGT_REG;
    else if (ioWin) begin
      if (cpuAddr[11:4] == 8'h50 && cpuAddr[3:0] <= 4'd11) rdTgt = TGT_REG;
      else if (cpuAddr[11:10] == 2'b10) rdTgt = TGT_COLOUR;
      else rdTgt = TGT_IO;
    end else begin
      case (cpuAddr[15:14])
        2'b00: rdTgt = TGT_RAM;
        2'b01: rdTgt = regs.cfg[1] ? TGT_RAM : TGT_LOROM;
        2'b10: case (regs.cfg[3:2])
                 2'b00:   rdTgt = TGT_HIROM;
                 2'b11:   rdTgt = TGT_RAM;
                 default: rdTgt = TGT_NONE;
               endcase
        default: case (regs.cfg[5:4])
                 2'b00:   rdTgt = (cpuAddr[13:12] == 2'b01) ? TGT_CHAR : TGT_TOPROM;
                 2'b11:   rdTgt = TGT_RAM;
                 default: rdTgt = TGT_NONE;
               endcase
      endcase
    end
    // writes fall through ROM and unmapped space to RAM
    if (cpuWe && (rdTgt == TGT_LOROM || rdTgt == TGT_HIROM || rdTgt == TGT_TOPROM ||
                  rdTgt == TGT_CHAR || rdTgt == TGT_NONE))
      tgt = TGT_RAM;
    else
      tgt = rdTgt;
  end

  // page relocation and shared window
  always_comb begin
    virt  = {regs.cfg[6], cpuAddr};
    zpSel = {regs.zpBank[0], regs.zpPage};
    spSel = {regs.spBank[0], regs.spPage};
    if (virt[16:8] == zpSel) phys = {zpSel[8], 8'h00, cpuAddr[7:0]};
    else if (virt[16:8] == spSel) phys = {spSel[8], 8'h01, cpuAddr[7:0]};
    else if (cpuAddr[15:8] == 8'h00) phys = {zpSel, cpuAddr[7:0]};
    else if (cpuAddr[15:8] == 8'h01) phys = {spSel, cpuAddr[7:0]};
    else phys = virt;
    case (regs.ramCfg[1:0])
      2'b00:   shAmt = 4'd10;
      2'b01:   shAmt = 4'd12;
      2'b10:   shAmt = 4'd13;
      default: shAmt = 4'd14;
    endcase
    invLow   = ~phys[15:0];
    botShare = regs.ramCfg[2] && ((phys[15:0] >> shAmt) == 16'h0);
    topShare = regs.ramCfg[3] && ((invLow >> shAmt) == 16'h0);
    ramAddr  = phys;
    if (phys[16] && (botShare || topShare)) ramAddr[16] = 1'b0;
  end

  // read data
  always_comb begin
    rdIdx = mirWin ? {1'b0, cpuAddr[2:0]} : cpuAddr[3:0];
    case (rdIdx)
      4'd0:  regVal = regs.cfg;
      4'd1, 4'd2, 4'd3, 4'd4: regVal = regs.pre[2'(rdIdx - 4'd1)];
      4'd5:  regVal = regs.mode;
      4'd6:  regVal = regs.ramCfg;
      4'd7:  regVal = regs.zpPage;
      4'd8:  regVal = regs.zpBank;
      4'd9:  regVal = regs.spPage;
      4'd10: regVal = regs.spBank;
      4'd11: regVal = VERSION_ID;
      default: regVal = 8'hFF;
    endcase
    case (tgt)
      TGT_RAM:    cpuRdData = ramRdData;
      TGT_LOROM, TGT_HIROM, TGT_TOPROM, TGT_CHAR: cpuRdData = romRdData;
      TGT_IO:     cpuRdData = ioRdData;
      TGT_COLOUR: cpuRdData = {4'hF, colRdData};
      TGT_REG:    cpuRdData = regVal;
      default:    cpuRdData = 8'hFF;
    endcase
  end
endmodule

// File: rtl/mmu_banker.sv
module mmu_banker
  import mmu_pkg::*;
#(
  parameter logic [7:0] VERSION_ID = 8'h20,
  parameter logic [7:0] MODE_RST = 8'hB9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cpuAddr,
  input  logic        cpuWe,
  input  logic [7:0]  cpuWrData,
  output logic [7:0]  cpuRdData,
  input  logic [7:0]  ramRdData,
  input  logic [7:0]  romRdData,
  input  logic [7:0]  ioRdData,
  input  logic [3:0]  colRdData,
  output logic [16:0] ramAddr,
  output logic        selRam,
  output logic        selLoRom,
  output logic        selHiRom,
  output logic        selTopRom,
  output logic        selChar,
  output logic        selIo,
  output logic        selColour,
  output logic        modeReq
);
  strobes_t strb;
  regs_t    regs;
  target_e  tgt;

  mmu_ctrl u_ctrl (
    .cpuAddr(cpuAddr), .cpuWe(cpuWe), .ioVisible(!regs.cfg[0]), .strb(strb)
  );

  mmu_regfile #(.MODE_RST(MODE_RST)) u_regs (
    .clk(clk), .rst(rst), .strb(strb), .wrData(cpuWrData),
    .regs(regs), .modeReq(modeReq)
  );

  mmu_map #(.VERSION_ID(VERSION_ID)) u_map (
    .cpuAddr(cpuAddr), .cpuWe(cpuWe), .regs(regs),
    .ramRdData(ramRdData), .romRdData(romRdData), .ioRdData(ioRdData),
    .colRdData(colRdData), .tgt(tgt), .ramAddr(ramAddr), .cpuRdData(cpuRdData)
  );

  assign selRam    = (tgt == TGT_RAM);
  assign selLoRom  = (tgt == TGT_LOROM);
  assign selHiRom  = (tgt == TGT_HIROM);
  assign selTopRom = (tgt == TGT_TOPROM);
  assign selChar   = (tgt == TGT_CHAR);
  assign selIo     = (tgt == TGT_IO);
  assign selColour = (tgt == TGT_COLOUR);
endmodule

// File: rtl/mmu_banker_chk.sv
module mmu_banker_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] cpuAddr,
  input logic        cpuWe,
  input logic [7:0]  cpuWrData,
  input logic [7:0]  cpuRdData,
  input logic        selRam,
  input logic        selLoRom,
  input logic        selHiRom,
  input logic        selTopRom,
  input logic        selChar,
  input logic        selIo,
  input logic        selColour,
  input logic        modeReq
);
  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({selRam, selLoRom, selHiRom, selTopRom, selChar, selIo, selColour}));

  // R5
  rom_write_ram_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuWe && (cpuAddr[15] ^ cpuAddr[14])) |-> selRam);

  // R10
  colour_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (selColour && !cpuWe) |-> (cpuRdData[7:4] == 4'hF));

  // R9
  version_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuAddr == 16'hD50B && !cpuWe && !selRam && !selChar) |-> (cpuRdData == 8'h20));

  // R6
  mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuWe && cpuAddr == 16'hFF00) ##1 (!cpuWe && cpuAddr == 16'hFF00)
      |-> (cpuRdData == $past(cpuWrData)));

  // R11
  mode_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    modeReq |=> !modeReq);

  // R11
  mode_cause_chk: assert property (@(posedge clk) disable iff (rst)
    modeReq |-> ($past(cpuWe) && $past(cpuAddr) == 16'hD505 && $past(cpuWrData[6])));
endmodule

bind mmu_banker mmu_banker_chk u_chk (
  .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuWrData(cpuWrData),
  .cpuRdData(cpuRdData), .selRam(selRam), .selLoRom(selLoRom), .selHiRom(selHiRom),
  .selTopRom(selTopRom), .selChar(selChar), .selIo(selIo), .selColour(selColour),
  .modeReq(modeReq)
);

// File: tb/tb_mmu_banker.sv
module tb_mmu_banker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpuAddr = '0;
  logic        cpuWe = 1'b0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  cpuRdData;
  logic [7:0]  ramRdData = 8'h5A;
  logic [7:0]  romRdData = 8'hC3;
  logic [7:0]  ioRdData = 8'h3C;
  logic [3:0]  colRdData = 4'h6;
  logic [16:0] ramAddr;
  logic selRam, selLoRom, selHiRom, selTopRom, selChar, selIo, selColour, modeReq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mmu_banker dut (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .ramRdData(ramRdData), .romRdData(romRdData),
    .ioRdData(ioRdData), .colRdData(colRdData), .ramAddr(ramAddr),
    .selRam(selRam), .selLoRom(selLoRom), .selHiRom(selHiRom), .selTopRom(selTopRom),
    .selChar(selChar), .selIo(selIo), .selColour(selColour), .modeReq(modeReq)
  );

  function automatic logic [6:0] sels();
    return {selColour, selIo, selChar, selTopRom, selHiRom, selLoRom, selRam};
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWe = 1'b1;
    @(negedge clk);
    cpuWe = 1'b0;
  endtask

  task automatic look(input logic [15:0] a);
    @(negedge clk);
    cpuAddr = a; cpuWe = 1'b0;
    #2;
  endtask

  // sel bit order: {colour, io, char, top, hi, lo, ram}
  task automatic t_reset();
    look(16'hD500); chk(cpuRdData, 8'h00, "R1 cfg");
    look(16'hD505); chk(cpuRdData, 8'hB9, "R1 mode");
    look(16'hD506); chk(cpuRdData, 8'h00, "R1 ramcfg");
    look(16'hD507); chk(cpuRdData, 8'h00, "R1 zp page");
    look(16'hD508); chk(cpuRdData, 8'h00, "R1 zp bank");
    look(16'hD509); chk(cpuRdData, 8'h01, "R1 sp page");
    look(16'hD50A); chk(cpuRdData, 8'h00, "R1 sp bank");
    chk(modeReq, 1'b0, "R1 modeReq");
  endtask

  task automatic t_rom_decode();
    look(16'h4000); chk(sels(), 7'b0000010, "R3 lo rom sel"); chk(cpuRdData, 8'hC3, "R3 rom data");
    look(16'h8000); chk(sels(), 7'b0000100, "R3 hi rom sel");
    look(16'hC000); chk(sels(), 7'b0001000, "R3 top rom sel");
    look(16'h0200); chk(sels(), 7'b0000001, "R3 ram sel"); chk(cpuRdData, 8'h5A, "R3 ram data");
    chk(ramAddr, 17'h00200, "R3 ram addr");
    look(16'hD000); chk(sels(), 7'b0100000, "R2 io sel"); chk(cpuRdData, 8'h3C, "R2 io data");
    look(16'hD800); chk(sels(), 7'b1000000, "R10 colour sel"); chk(cpuRdData, 8'hF6, "R10 colour data");
    wr(16'hD500, 8'h01);
    look(16'hD000); chk(sels(), 7'b0010000, "R2 char when io off");
    wr(16'hFF00, 8'h3F);
    look(16'h4000); chk(sels(), 7'b0000001, "R3 lo ram"); chk(ramAddr, 17'h04000, "R3 lo ram addr");
    look(16'hD000); chk(sels(), 7'b0000001, "R2 ram when io off"); chk(ramAddr, 17'h0D000, "R2 ram addr");
  endtask

  task automatic t_unmapped_write();
    wr(16'hFF00, 8'h04);
    look(16'h8000); chk(sels(), 7'b0, "R3 unmapped sel"); chk(cpuRdData, 8'hFF, "R3 unmapped data");
    @(negedge clk); cpuAddr = 16'h8000; cpuWe = 1'b1; cpuWrData = 8'h11; #2;
    chk(selRam, 1'b1, "R5 unmapped write"); chk(ramAddr, 17'h08000, "R5 addr");
    @(negedge clk); cpuAddr = 16'h4000; #2;
    chk(selRam, 1'b1, "R5 rom write"); chk(ramAddr, 17'h04000, "R5 rom addr");
    @(negedge clk); cpuWe = 1'b0;
  endtask

  task automatic t_bank_mirror();
    wr(16'hFF00, 8'h7F);
    look(16'h1234); chk(ramAddr, 17'h11234, "R4 bank1");
    look(16'hFF00); chk(cpuRdData, 8'h7F, "R6 mirror read");
    wr(16'hFF00, 8'h00);
    wr(16'hD502, 8'h7F);
    wr(16'hFF02, 8'h99);
    look(16'hFF00); chk(cpuRdData, 8'h7F, "R6 preload 2");
    wr(16'hFF00, 8'h00);
    wr(16'hD501, 8'h3E);
    wr(16'hFF01, 8'h00);
    look(16'hFF00); chk(cpuRdData, 8'h3E, "R6 preload 1");
    wr(16'hFF00, 8'h00);
  endtask

  task automatic t_reloc();
    wr(16'hD507, 8'h20);
    look(16'h0010); chk(ramAddr, 17'h02010, "R7 zp moved");
    look(16'h2010); chk(ramAddr, 17'h00010, "R7 zp swapped");
    wr(16'hD508, 8'h01);
    look(16'h0010); chk(ramAddr, 17'h12010, "R7 zp bank1");
    look(16'h2010); chk(ramAddr, 17'h02010, "R7 bank0 untouched");
    wr(16'hD509, 8'h30);
    look(16'h0145); chk(ramAddr, 17'h03045, "R7 stack moved");
    look(16'h3045); chk(ramAddr, 17'h00145, "R7 stack swapped");
    wr(16'hD507, 8'h00); wr(16'hD508, 8'h00); wr(16'hD509, 8'h01);
  endtask

  task automatic t_common();
    wr(16'hD506, 8'h05);
    wr(16'hFF00, 8'h40);
    look(16'h0800); chk(ramAddr, 17'h00800, "R8 bottom shared");
    look(16'h1000); chk(ramAddr, 17'h11000, "R8 outside bottom");
    wr(16'hD506, 8'h0B);
    @(negedge clk); cpuAddr = 16'hE000; cpuWe = 1'b1; #2;
    chk(ramAddr, 17'h0E000, "R8 top shared");
    @(negedge clk); cpuAddr = 16'hB000; #2;
    chk(ramAddr, 17'h1B000, "R8 outside top");
    @(negedge clk); cpuWe = 1'b0;
    wr(16'hFF00, 8'h00);
    wr(16'hD506, 8'h00);
  endtask

  task automatic t_version_mode();
    wr(16'hD50B, 8'h55);
    look(16'hD50B); chk(cpuRdData, 8'h20, "R9 version");
    wr(16'hD505, 8'h40);
    #1; chk(modeReq, 1'b1, "R11 pulse high");
    @(negedge clk); #1; chk(modeReq, 1'b0, "R11 pulse ends");
    look(16'hD505); chk(cpuRdData, 8'h40, "R11 stored");
    wr(16'hD505, 8'h39);
    #1; chk(modeReq, 1'b0, "R11 no pulse");
    look(16'hD505); chk(cpuRdData, 8'h39, "R11 stored 2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rom_decode();
    t_unmapped_write();
    t_bank_mirror();
    t_reloc();
    t_common();
    t_version_mode();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule